// File: doc/BRIEF.md
# Radix-4 Booth Multiplier

This block multiplies two unsigned operands of a parameterized width and returns the full double-width product. Instead of forming one shifted copy of the multiplicand per multiplier bit, it recodes the multiplier two bits at a time. Each recoded digit selects a signed multiple of the multiplicand: zero, once or twice it, positive or negative. This roughly halves the number of rows that have to be summed.

The multiplier operand is read as overlapping three-bit windows. Neighbouring windows share one bit. An implicit zero sits below the least significant bit, and two zero bits are appended above the most significant bit so that unsigned values decode correctly. Each selected row is sign-extended, shifted by twice its digit index, and added. A negative row is formed by bitwise inversion, and its +1 is supplied as a separate carry-in at the row's base position.

A parameter chooses between a purely combinational result and a result held in one output register stage. A valid flag travels alongside the operands with the same latency as the product.

Top module: `booth_mult`

## Requirements
- R1: With the output register enabled (REG_OUT=1), `product` equals the full 2*WIDTH-bit unsigned product `opA*opB` one clock after a cycle in which `inValid` is 1.
- R2: With REG_OUT=1, `outValid` equals the value `inValid` had one clock earlier.
- R3: With REG_OUT=1, a cycle with `inValid` at 0 leaves `product` unchanged, whatever values `opA` and `opB` carry.
- R4: Window k is {b[2k+1], b[2k], b[2k-1]} with b[-1]=0 and two zero bits above b[WIDTH-1], which gives (WIDTH+2)/2 windows. The windows map as follows: 000 and 111 give 0; 001 and 010 give +a; 011 gives +2a; 100 gives -2a; 101 and 110 give -a. The product is exact for the extreme operands, including both operands all ones and either operand zero.
- R5: With REG_OUT=0, `product` equals `opA*opB` in the same cycle, and `outValid` equals `inValid` in the same cycle.
- R6: While `rstN` is 0, the registered variant holds `product` at 0 and `outValid` at 0.
- R7: The same design gives exact 128-bit products at WIDTH=64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | The operands in this cycle are to be multiplied |
| opA | input | WIDTH | Multiplicand, unsigned |
| opB | input | WIDTH | Multiplier, unsigned, Booth-recoded |
| outValid | output | 1 | `product` carries a fresh result |
| product | output | 2*WIDTH | Full unsigned product |

## Verification
In the registered variant, two things can happen in the same clock edge: the output register presents the product of the previous pair, and it decides whether to capture the new pair or hold. The bench provokes this with long runs of back-to-back valid operands (every pair of 8-bit values, one per cycle) and with valid-to-idle transitions where the idle cycles carry changing operands. A behavioural model in the bench tracks what the register should hold after each edge. It is compared with both outputs on every clock, so a product that is captured on an idle cycle, or that lags by a cycle, shows up at once.

// File: rtl/booth_mult_pkg.sv
`timescale 1ns/1ps
package booth_mult_pkg;

  // Decoded Booth digit: zero row, double multiple, negated row.
  typedef struct packed {
    logic zero;
    logic two;
    logic neg;
  } boothSel_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;
  } dpStrobe_t;

endpackage

// File: rtl/booth_mult_recode.sv
`timescale 1ns/1ps
module booth_mult_recode
  import booth_mult_pkg::*;
(
  input  logic [2:0] window,
  output boothSel_t  sel
);

  // Window bits are {upper, centre, lower}; the lower bit is the shared one.
  always_comb begin
    sel = '0;
    case (window)
      3'b001, 3'b010: sel = '0;                 // +a
      3'b011:         sel.two = 1'b1;           // +2a
      3'b100:         begin sel.two = 1'b1; sel.neg = 1'b1; end  // -2a
      3'b101, 3'b110: sel.neg = 1'b1;           // -a
      default:        sel.zero = 1'b1;          // 000, 111
    endcase
  end

endmodule

// File: rtl/booth_mult_ctrl.sv
`timescale 1ns/1ps
module booth_mult_ctrl
  import booth_mult_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output dpStrobe_t strobe,
  output logic      outValid
);

  assign strobe.capture = inValid;

  generate
    if (REG_OUT) begin : g_reg
      logic validQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate

endmodule

// File: rtl/booth_mult_datapath.sv
`timescale 1ns/1ps
module booth_mult_datapath
  import booth_mult_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] product
);

  localparam int NGROUP = (WIDTH + 2) / 2;   // ceil((WIDTH+1)/2)
  localparam int SUMW   = 2 * WIDTH;
  localparam int MULW   = WIDTH + 2;         // room for 2a plus sign
  localparam int BEXT   = 2 * NGROUP + 1;
  localparam int BPAD   = BEXT - WIDTH - 1;
  localparam int SEXT   = SUMW - MULW;

  logic [BEXT-1:0] bExt;
  logic [MULW-1:0] aOne;
  logic [MULW-1:0] aTwo;

  assign bExt = {{BPAD{1'b0}}, opB, 1'b0};
  assign aOne = {2'b00, opA};
  assign aTwo = {1'b0, opA, 1'b0};

  boothSel_t       selG  [NGROUP];
  logic [SUMW-1:0] ppRow [NGROUP];
  logic [SUMW-1:0] cinRow[NGROUP];

  generate
    for (genvar g = 0; g < NGROUP; g++) begin : g_row
      logic [MULW-1:0] mag;
      logic [MULW-1:0] rowBits;

      booth_mult_recode u_rec (
        .window (bExt[2*g+2 -: 3]),
        .sel    (selG[g])
      );

      assign mag     = selG[g].zero ? '0 : (selG[g].two ? aTwo : aOne);
      assign rowBits = selG[g].neg ? ~mag : mag;
      assign ppRow[g]  = {{SEXT{rowBits[MULW-1]}}, rowBits} << (2 * g);
      assign cinRow[g] = {{(SUMW-1){1'b0}}, selG[g].neg} << (2 * g);
    end
  endgenerate

  logic [SUMW-1:0] sumAll;

  always_comb begin
    sumAll = '0;
    for (int k = 0; k < NGROUP; k++) begin
      sumAll = sumAll + ppRow[k] + cinRow[k];
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [SUMW-1:0] productQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               productQ <= '0;
        else if (strobe.capture) productQ <= sumAll;
      end
      assign product = productQ;
    end else begin : g_comb
      assign product = sumAll;
    end
  endgenerate

endmodule

// File: rtl/booth_mult.sv
`timescale 1ns/1ps
module booth_mult
  import booth_mult_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic               outValid,
  output logic [2*WIDTH-1:0] product
);

  dpStrobe_t strobe;

  booth_mult_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  booth_mult_datapath #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .product (product)
  );

endmodule

// File: rtl/booth_mult_chk.sv
`timescale 1ns/1ps
module booth_mult_chk #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [WIDTH-1:0]   opA,
  input logic [WIDTH-1:0]   opB,
  input logic               outValid,
  input logic [2*WIDTH-1:0] product
);

  logic [2*WIDTH-1:0] refProd;
  assign refProd = {{WIDTH{1'b0}}, opA} * {{WIDTH{1'b0}}, opB};

  generate
    if (REG_OUT) begin : g_reg
      // R1
      prod_match_chk: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> product == $past(refProd));
      // R2
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> outValid == $past(inValid));
      // R3
      hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> $stable(product));
      // R4
      zero_chk: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && (opA == '0 || opB == '0)) |=> product == '0);
    end else begin : g_comb
      // R5
      comb_match_chk: assert property (@(posedge clk) disable iff (!rstN)
        inValid |-> product == refProd);
      // R5
      comb_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
        outValid == inValid);
    end
  endgenerate

endmodule

bind booth_mult booth_mult_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opA      (opA),
  .opB      (opB),
  .outValid (outValid),
  .product  (product)
);

// File: tb/booth_mult_tb.sv
`timescale 1ns/1ps
module booth_mult_tb;

  localparam int W  = 8;
  localparam int WW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic           inValid;
  logic [W-1:0]   a, b;
  logic           outValid;
  logic [2*W-1:0] prod;

  logic            wValid;
  logic [WW-1:0]   wa, wb;
  logic            wOutValid;
  logic [2*WW-1:0] wProd;

  booth_mult #(.WIDTH(W), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(a), .opB(b),
    .outValid(outValid), .product(prod)
  );

  booth_mult #(.WIDTH(WW), .REG_OUT(1'b0)) u_wide (
    .clk(clk), .rstN(rstN), .inValid(wValid), .opA(wa), .opB(wb),
    .outValid(wOutValid), .product(wProd)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  logic [2*W-1:0] expProd;
  logic           expValid;

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, update the model at the rising edge,
  // compare at the next falling edge.
  task automatic step(logic v, logic [W-1:0] x, logic [W-1:0] y, string tag);
    inValid = v;
    a = x;
    b = y;
    @(posedge clk);
    if (v) expProd = (2*W)'(x) * (2*W)'(y);
    expValid = v;
    @(negedge clk);
    check(tag, 128'(prod), 128'(expProd));
    check("R2", 128'(outValid), 128'(expValid));
  endtask

  task automatic wstep(logic [WW-1:0] x, logic [WW-1:0] y);
    wValid = 1'b1;
    wa = x;
    wb = y;
    #1;
    check("R7", wProd, 128'(x) * 128'(y));
    check("R5", 128'(wOutValid), 128'(1'b1));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    inValid = 1'b0; a = '0; b = '0;
    wValid = 1'b0; wa = '0; wb = '0;
    expProd = '0; expValid = 1'b0;

    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6", 128'(prod), 128'(0));
    check("R6", 128'(outValid), 128'(0));
    rstN = 1'b1;
    @(negedge clk);

    // R1: every operand pair, back to back
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        step(1'b1, W'(x), W'(y), "R1");

    // R4: extremes
    step(1'b1, 8'hFF, 8'hFF, "R4");
    step(1'b1, 8'hFF, 8'h00, "R4");
    step(1'b1, 8'h00, 8'hFF, "R4");
    step(1'b1, 8'h80, 8'hAA, "R4");
    step(1'b1, 8'h55, 8'h80, "R4");

    // R3: idle cycles with moving operands must hold the product
    step(1'b1, 8'hA5, 8'h3C, "R1");
    for (int i = 0; i < 6; i++)
      step(1'b0, W'($urandom), W'($urandom), "R3");

    // R1/R3: alternating valid and idle
    for (int i = 0; i < 200; i++) begin
      logic v;
      v = 1'(i % 3 != 0);
      step(v, W'($urandom), W'($urandom), v ? "R1" : "R3");
    end

    // R5: combinational variant with no valid
    wValid = 1'b0;
    #1;
    check("R5", 128'(wOutValid), 128'(0));

    // R7: wide operands
    wstep('1, '1);
    wstep('0, '1);
    wstep(64'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    wstep(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001);
    for (int i = 0; i < 2000; i++)
      wstep({$urandom, $urandom}, {$urandom, $urandom});

    finish_run();
  end

endmodule